// File: doc/BRIEF.md
# Sample Run Length Terminator

This block ends an acquisition run after a programmed number of samples. The host programs the sample count as one 8-bit field inside a long serial control word. The word goes into a shadow register one bit at a time, and the block only uses it after a strobe. A strobe copies the count field into a holding register. A run-start request then raises the run flag and copies the held count into an 8-bit down counter. Both happen in the same cycle.

While the run flag is set, each sample tick lowers the counter by one. The counter is built from cascaded 4-bit stages. A stage only decrements when every stage below it reads zero. The tick that brings the counter to zero ends the run: the run flag clears and a one-cycle done pulse appears. The run flag gates sample ticks, so ticks that arrive while no run is active have no effect.

Top module: `sample_run_limiter`

## Requirements
- R1: The control word is `WORD_W` (default 80) bits wide and is shifted in MSB first. On each cycle with `cfg_shift` high, `cfg_data` enters bit 0 and every other bit moves up one place. After `WORD_W` shifts, the first bit shifted sits at bit `WORD_W-1`.
- R2: The sample count is the field at bits `[CNT_LSB+CNT_W-1:CNT_LSB]` (default `[23:16]`) of the shadow word. It is copied into the held count only on a cycle with `cfg_strobe` high. Shifting without a strobe leaves the held count unchanged, and the other bits of the word never affect it.
- R3: A cycle with `run_start` high sets `run_active` and loads the held count into the counter. Both show on the outputs after that clock edge.
- R4: While `run_active` is low, `smp_tick` has no effect: `run_active` and `run_done` stay low.
- R5: With a count N from 1 to 255 loaded, the run ends on the Nth accepted tick. After that edge `run_active` is low and `run_done` is high.
- R6: `run_done` is high for exactly one cycle per completed run.
- R7: A loaded count of zero runs for 256 ticks before ending.
- R8: The counter is made of `STAGE_W`-bit stages (default 4). A stage decrements only when all lower stages are zero, so counts that cross a stage boundary end on the correct tick.
- R9: If `run_start` and `smp_tick` are high in the same cycle, the start wins and the tick is not counted. A start during a run reloads the counter and keeps `run_active` high.
- R10: After reset, `run_active` and `run_done` are low and the held count is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_data | input | 1 | Serial control data bit |
| cfg_shift | input | 1 | Shift enable: takes in one control bit |
| cfg_strobe | input | 1 | Copies the count field from the shadow word |
| run_start | input | 1 | Starts a run and loads the counter |
| smp_tick | input | 1 | One sample taken |
| run_active | output | 1 | Run flag: high while acquisition may continue |
| run_done | output | 1 | One-cycle pulse when the programmed count is reached |

## Verification
The hardest cases to reach are the ones where the count wraps or crosses a stage boundary. One is the zero count, which needs 256 accepted ticks. The others are counts such as 16 and 17, where the upper stage must borrow at exactly the right tick. The bench reaches them by shifting full 80-bit words that hold the count surrounded by all-ones filler bits. It then strobes, starts a run and applies a counted burst of ticks that stops one short of the expected end or lands exactly on it. A partial shift without a strobe, followed by a new run, shows that only a strobe changes the active count.

// File: rtl/sre_pkg.sv
package sre_pkg;

    localparam int unsigned DEF_WORD_W  = 80;
    localparam int unsigned DEF_CNT_W   = 8;
    localparam int unsigned DEF_STAGE_W = 4;
    localparam int unsigned DEF_CNT_LSB = 16;

    typedef struct packed {
        logic run;
        logic done;
    } run_state_t;

endpackage

// File: rtl/sre_ctl_shifter.sv
module sre_ctl_shifter #(
    parameter int unsigned WORD_W  = sre_pkg::DEF_WORD_W,
    parameter int unsigned CNT_W   = sre_pkg::DEF_CNT_W,
    parameter int unsigned CNT_LSB = sre_pkg::DEF_CNT_LSB
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_data,
    input  logic             cfg_shift,
    input  logic             cfg_strobe,
    output logic [CNT_W-1:0] held_count
);

    typedef struct packed {
        logic [WORD_W-1:0] shadow;
        logic [CNT_W-1:0]  held;
    } shf_state_t;

    shf_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cfg_strobe) begin
            st_d.held = st_q.shadow[CNT_LSB +: CNT_W];
        end
        if (cfg_shift) begin
            st_d.shadow = {st_q.shadow[WORD_W-2:0], cfg_data};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign held_count = st_q.held;

endmodule

// File: rtl/sre_down_counter.sv
module sre_down_counter #(
    parameter int unsigned CNT_W   = sre_pkg::DEF_CNT_W,
    parameter int unsigned STAGE_W = sre_pkg::DEF_STAGE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic             term
);

    localparam int unsigned N_ST = CNT_W / STAGE_W;

    logic [STAGE_W-1:0] stage_d [N_ST];
    logic [STAGE_W-1:0] stage_q [N_ST];
    logic [N_ST:0]      brw;
    logic [CNT_W-1:0]   cnt_flat;

    assign brw[0] = dec;

    for (genvar g = 0; g < N_ST; g++) begin : g_stage
        assign brw[g+1] = brw[g] & (stage_q[g] == '0);
        assign cnt_flat[g*STAGE_W +: STAGE_W] = stage_q[g];
    end

    always_comb begin
        for (int i = 0; i < N_ST; i++) begin
            if (load) begin
                stage_d[i] = load_val[i*STAGE_W +: STAGE_W];
            end else if (brw[i]) begin
                stage_d[i] = stage_q[i] - STAGE_W'(1);
            end else begin
                stage_d[i] = stage_q[i];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N_ST; i++) begin
                stage_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < N_ST; i++) begin
                stage_q[i] <= stage_d[i];
            end
        end
    end

    assign term = dec & (cnt_flat == CNT_W'(1));

endmodule

// File: rtl/sample_run_limiter.sv
module sample_run_limiter #(
    parameter int unsigned WORD_W  = sre_pkg::DEF_WORD_W,
    parameter int unsigned CNT_W   = sre_pkg::DEF_CNT_W,
    parameter int unsigned STAGE_W = sre_pkg::DEF_STAGE_W,
    parameter int unsigned CNT_LSB = sre_pkg::DEF_CNT_LSB
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_data,
    input  logic cfg_shift,
    input  logic cfg_strobe,
    input  logic run_start,
    input  logic smp_tick,
    output logic run_active,
    output logic run_done
);

    import sre_pkg::*;

    logic [CNT_W-1:0] held_count;
    logic             tick_ok;
    logic             term;
    run_state_t       rs_d, rs_q;

    sre_ctl_shifter #(
        .WORD_W (WORD_W),
        .CNT_W  (CNT_W),
        .CNT_LSB(CNT_LSB)
    ) i_shifter (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_data  (cfg_data),
        .cfg_shift (cfg_shift),
        .cfg_strobe(cfg_strobe),
        .held_count(held_count)
    );

    assign tick_ok = smp_tick & rs_q.run & ~run_start;

    sre_down_counter #(
        .CNT_W  (CNT_W),
        .STAGE_W(STAGE_W)
    ) i_counter (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (run_start),
        .load_val(held_count),
        .dec     (tick_ok),
        .term    (term)
    );

    always_comb begin
        rs_d      = rs_q;
        rs_d.done = term;
        if (run_start) begin
            rs_d.run = 1'b1;
        end else if (term) begin
            rs_d.run = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rs_q <= '0;
        end else begin
            rs_q <= rs_d;
        end
    end

    assign run_active = rs_q.run;
    assign run_done   = rs_q.done;

endmodule

// File: rtl/sre_checker.sv
module sre_checker (
    input logic clk,
    input logic rst_n,
    input logic run_start,
    input logic smp_tick,
    input logic run_active,
    input logic run_done
);

    AST_START_SETS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        run_start |=> run_active); // R3

    AST_IDLE_TICK_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_active && !run_start) |=> (!run_active && !run_done)); // R4

    AST_DONE_ENDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        run_done |-> !run_active); // R5

    AST_DONE_FROM_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        run_done |-> ($past(smp_tick) && $past(run_active) && !$past(run_start))); // R9

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        run_done |=> !run_done); // R6

endmodule

bind sample_run_limiter sre_checker i_sre_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_start (run_start),
    .smp_tick  (smp_tick),
    .run_active(run_active),
    .run_done  (run_done)
);

// File: tb/test_sample_run_limiter.sv
module test_sample_run_limiter;

    localparam int CLK_PERIOD = 10;
    localparam int WORD_W     = 80;
    localparam int CNT_LSB    = 16;

    typedef struct packed {
        logic [7:0] n;
        logic [8:0] ticks;
        logic       run_exp;
        logic [1:0] dones_exp;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{8'd3,   9'd2,   1'b1, 2'd0},  // R5 one short
        '{8'd3,   9'd3,   1'b0, 2'd1},  // R5 exact
        '{8'd1,   9'd1,   1'b0, 2'd1},  // R5 minimum
        '{8'd16,  9'd16,  1'b0, 2'd1},  // R8 stage borrow
        '{8'd17,  9'd16,  1'b1, 2'd0},  // R8 one short across stage
        '{8'd17,  9'd17,  1'b0, 2'd1},  // R8
        '{8'd255, 9'd255, 1'b0, 2'd1},  // R5 maximum
        '{8'd0,   9'd255, 1'b1, 2'd0},  // R7 one short
        '{8'd0,   9'd256, 1'b0, 2'd1}   // R7 full wrap
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_data = 1'b0;
    logic cfg_shift = 1'b0;
    logic cfg_strobe = 1'b0;
    logic run_start = 1'b0;
    logic smp_tick = 1'b0;
    logic run_active;
    logic run_done;

    int checks = 0;
    int fails  = 0;
    int dones  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sample_run_limiter i_sample_run_limiter (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_data  (cfg_data),
        .cfg_shift (cfg_shift),
        .cfg_strobe(cfg_strobe),
        .run_start (run_start),
        .smp_tick  (smp_tick),
        .run_active(run_active),
        .run_done  (run_done)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic shift_bits(input logic [WORD_W-1:0] w, input int nbits);
        for (int i = WORD_W-1; i >= WORD_W-nbits; i--) begin
            cfg_data  = w[i];
            cfg_shift = 1'b1;
            @(negedge clk);
        end
        cfg_shift = 1'b0;
        cfg_data  = 1'b0;
    endtask

    task automatic program_count(input logic [7:0] n);
        logic [WORD_W-1:0] w;
        w = '1;
        w[CNT_LSB +: 8] = n;
        shift_bits(w, WORD_W);
        cfg_strobe = 1'b1;
        @(negedge clk);
        cfg_strobe = 1'b0;
    endtask

    task automatic start_run();
        run_start = 1'b1;
        @(negedge clk);
        run_start = 1'b0;
        if (run_done) dones++;
    endtask

    task automatic ticks(input int k);
        for (int i = 0; i < k; i++) begin
            smp_tick = 1'b1;
            @(negedge clk);
            smp_tick = 1'b0;
            if (run_done) dones++;
        end
    endtask

    task automatic finish_run();
        ticks(300);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        check("R10 run_active", int'(run_active), 0);
        check("R10 run_done", int'(run_done), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 held count zero after reset: run lasts 256 ticks
        start_run();
        dones = 0;
        ticks(255);
        check("R10 run after 255 ticks", int'(run_active), 1);
        ticks(1);
        check("R10 run ended at 256", int'(run_active), 0);
        check("R10 one done", dones, 1);

        // Vector table: R1 R2 R5 R7 R8
        for (int v = 0; v < NV; v++) begin
            program_count(VECS[v].n);
            start_run();
            check("R3 run set by start", int'(run_active), 1);
            dones = 0;
            ticks(int'(VECS[v].ticks));
            check("R5 run flag after ticks", int'(run_active), int'(VECS[v].run_exp));
            check("R5 done pulses", dones, int'(VECS[v].dones_exp));
            finish_run();
        end

        // R6 done single cycle
        program_count(8'd2);
        start_run();
        ticks(1);
        smp_tick = 1'b1;
        @(negedge clk);
        smp_tick = 1'b0;
        check("R6 done high", int'(run_done), 1);
        @(negedge clk);
        check("R6 done low next cycle", int'(run_done), 0);

        // R4 ticks while idle ignored
        dones = 0;
        ticks(20);
        check("R4 idle run stays low", int'(run_active), 0);
        check("R4 idle no done", dones, 0);

        // R2 partial shift without strobe keeps count 5
        program_count(8'd5);
        shift_bits({WORD_W{1'b0}}, 40);
        start_run();
        dones = 0;
        ticks(4);
        check("R2 partial shift count kept (4 ticks)", int'(run_active), 1);
        ticks(1);
        check("R2 partial shift count kept (5 ticks)", int'(run_active), 0);

        // R1 MSB first: word shifted with field bits reversed order matters (count 0x01 vs 0x80)
        program_count(8'h80);
        start_run();
        dones = 0;
        ticks(127);
        check("R1 MSB-first 0x80 not ended at 127", int'(run_active), 1);
        ticks(1);
        check("R1 MSB-first 0x80 ended at 128", int'(run_active), 0);

        // R9 start and tick together: tick not counted
        program_count(8'd2);
        run_start = 1'b1;
        smp_tick  = 1'b1;
        @(negedge clk);
        run_start = 1'b0;
        smp_tick  = 1'b0;
        dones = 0;
        ticks(1);
        check("R9 simultaneous tick ignored", int'(run_active), 1);
        ticks(1);
        check("R9 ends after 2 counted ticks", int'(run_active), 0);

        // R9 restart during run reloads
        program_count(8'd4);
        start_run();
        ticks(3);
        start_run();
        check("R9 restart keeps run", int'(run_active), 1);
        ticks(3);
        check("R9 reloaded count not ended", int'(run_active), 1);
        ticks(1);
        check("R9 reloaded count ended", int'(run_active), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule